// File: doc/BRIEF.md
# Parallel Port Byte FIFO with Service Interrupt

This block holds the byte queue that sits between a host and the cable side of an enhanced-capability parallel port. It also produces the status bits and the service interrupt that pace transfers. A direction input chooses the path. In the forward direction, host register writes fill the queue and a peripheral-side valid/ready sink empties it. In the reverse direction, a peripheral-side valid/ready source fills the queue and host register reads empty it. The host can see four occupancy flags: has room, is full, holds data and is empty.

Transfers are paced by a single service bit. Only hardware sets the bit, and only while it is clear. What sets it depends on the mode. With DMA enabled, the event is a terminal-count pulse from the DMA engine. With DMA disabled, the event is a free-space threshold in the forward direction and a fill threshold in the reverse direction. While the bit is set it masks every further service event and the DMA request. Software clears the bit to re-arm the logic, and software can set the bit to mask it, but a software set never raises the interrupt. The interrupt request rises with each hardware set of the service bit and stays high until software clears the bit.

Top module: `pp_fifo_svc`

## Requirements
- R1: After reset the queue is empty (`empty_o`=1, `not_empty_o`=0, `full_o`=0, `not_full_o`=1), `svc_o`=1, `irq_o`=0 and `dma_req_o`=0.
- R2: Bytes leave the queue in the order they entered. `full_o` is 1 exactly when 16 bytes are held and `empty_o` is 1 exactly when none are held. `not_full_o` and `not_empty_o` are their complements. Each flag reflects the pushes and pops of the previous clock edge.
- R3: A push attempted while `full_o`=1 and a pop attempted while `empty_o`=1 are ignored. Neither the held count nor the stored bytes change.
- R4: `dir_i`=0 (forward) takes pushes from `host_wr_i` and pops through `pout_valid_o`/`pout_ready_i`. `dir_i`=1 (reverse) takes pushes through `pin_valid_i`/`pin_ready_o` and pops from `host_rd_i`. The strobes of the inactive path are ignored. `pin_ready_o` is 0 in forward and `pout_valid_o` is 0 in reverse.
- R5: `svc_wr_i`=1 with `svc_wdata_i`=1 sets `svc_o` on the next edge and leaves `irq_o` unchanged.
- R6: While `svc_o`=1, no service event changes `svc_o` or `irq_o`, and `dma_req_o` is 0.
- R7: With `dma_en_i`=1 and `svc_o`=0, a cycle with `dma_tc_i`=1 sets `svc_o` and `irq_o` on the next edge. The thresholds have no effect in this mode.
- R8: With `dma_en_i`=0, `dir_i`=0 and `svc_o`=0, `svc_o` and `irq_o` are set on the next edge whenever (16 minus held bytes) is at least `wr_thr_i`.
- R9: With `dma_en_i`=0, `dir_i`=1 and `svc_o`=0, `svc_o` and `irq_o` are set on the next edge whenever the held byte count is at least `rd_thr_i`.
- R10: `irq_o` stays 1 until a software write of 0 to the service bit, which clears both `svc_o` and `irq_o` on the next edge. In the same cycle, the software write takes priority over a hardware event.
- R11: `dma_req_o` is 1 exactly when `dma_en_i`=1, `svc_o`=0 and the queue has room (forward) or holds data (reverse).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_i | input | 1 | Transfer direction, 0 forward, 1 reverse |
| dma_en_i | input | 1 | DMA mode enable |
| dma_tc_i | input | 1 | Terminal-count pulse from the DMA engine |
| wr_thr_i | input | 4 | Free-space threshold for forward service |
| rd_thr_i | input | 4 | Fill threshold for reverse service |
| host_wr_i | input | 1 | Host write strobe (push in forward) |
| host_wdata_i | input | 8 | Host write byte |
| host_rd_i | input | 1 | Host read strobe (pop in reverse) |
| host_rdata_o | output | 8 | Byte at the head of the queue |
| svc_wr_i | input | 1 | Software write strobe for the service bit |
| svc_wdata_i | input | 1 | Value written to the service bit |
| svc_o | output | 1 | Service bit |
| irq_o | output | 1 | Latched interrupt request |
| dma_req_o | output | 1 | DMA request |
| full_o | output | 1 | Queue full |
| empty_o | output | 1 | Queue empty |
| not_full_o | output | 1 | At least one free byte |
| not_empty_o | output | 1 | At least one held byte |
| pin_valid_i | input | 1 | Peripheral byte offered (reverse fill) |
| pin_data_i | input | 8 | Peripheral byte |
| pin_ready_o | output | 1 | Queue accepts a peripheral byte |
| pout_valid_o | output | 1 | Byte available to the peripheral (forward drain) |
| pout_data_o | output | 8 | Byte offered to the peripheral |
| pout_ready_i | input | 1 | Peripheral takes the byte |

## Verification
The threshold comparison is the hard part to reach from the ports. A given outcome needs a given occupancy and a given threshold, and it has to be seen while the service bit is clear. Once the bit sets, it masks everything that follows. The stimulus keeps the bit masked while it steps the queue through every fill level from 0 to 16 in both directions. At each level it sweeps all sixteen threshold values, and for each one it clears the bit for a single evaluation and then masks it again. The threshold of the inactive direction is held at 0 throughout, so an implementation that compares against the wrong threshold fires and is caught.

// File: rtl/pp_fifo_pkg.sv
package pp_fifo_pkg;

    typedef enum logic {
        PP_FWD = 1'b0,
        PP_REV = 1'b1
    } pp_dir_e;

    typedef struct packed {
        logic svc;
        logic irq;
    } pp_svc_state_t;

endpackage

// File: rtl/pp_fifo_route.sv
module pp_fifo_route
    import pp_fifo_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          dir_i,
    input  logic          host_wr_i,
    input  logic [DW-1:0] host_wdata_i,
    input  logic          host_rd_i,
    input  logic          pin_valid_i,
    input  logic [DW-1:0] pin_data_i,
    input  logic          pout_ready_i,
    input  logic          full_i,
    input  logic          empty_i,
    output logic          push_o,
    output logic [DW-1:0] push_data_o,
    output logic          pop_o,
    output logic          pin_ready_o,
    output logic          pout_valid_o
);

    pp_dir_e dir;
    assign dir = pp_dir_e'(dir_i);

    always_comb begin
        push_o       = 1'b0;
        push_data_o  = host_wdata_i;
        pop_o        = 1'b0;
        pin_ready_o  = 1'b0;
        pout_valid_o = 1'b0;
        if (dir == PP_FWD) begin
            push_o       = host_wr_i & ~full_i;
            push_data_o  = host_wdata_i;
            pout_valid_o = ~empty_i;
            pop_o        = pout_ready_i & ~empty_i;
        end else begin
            pin_ready_o  = ~full_i;
            push_o       = pin_valid_i & ~full_i;
            push_data_o  = pin_data_i;
            pop_o        = host_rd_i & ~empty_i;
        end
    end

endmodule

// File: rtl/pp_fifo_store.sv
module pp_fifo_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic [DW-1:0]              push_data_i,
    input  logic                       pop_i,
    output logic [DW-1:0]              head_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o,
    output logic [$clog2(DEPTH+1)-1:0] free_o,
    output logic                       full_o,
    output logic                       empty_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_P  = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
    } store_state_t;

    store_state_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_P) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.wr_ptr = bump(st_q.wr_ptr);
        end
        if (pop_i) begin
            st_d.rd_ptr = bump(st_q.rd_ptr);
        end
        case ({push_i, pop_i})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_i && (st_q.wr_ptr == PTR_W'(i))) begin
                mem_q[i] <= push_data_i;
            end
        end
    end

    assign head_o  = mem_q[st_q.rd_ptr];
    assign count_o = st_q.count;
    assign free_o  = DEPTH_C - st_q.count;
    assign full_o  = (st_q.count == DEPTH_C);
    assign empty_o = (st_q.count == '0);

endmodule

// File: rtl/pp_svc_ctl.sv
module pp_svc_ctl
    import pp_fifo_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int THR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_i,
    input  logic             dma_en_i,
    input  logic             dma_tc_i,
    input  logic [THR_W-1:0] wr_thr_i,
    input  logic [THR_W-1:0] rd_thr_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] free_i,
    input  logic             full_i,
    input  logic             empty_i,
    input  logic             sw_wr_i,
    input  logic             sw_val_i,
    output logic             svc_o,
    output logic             irq_o,
    output logic             dma_req_o
);

    localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

    pp_dir_e       dir;
    pp_svc_state_t sv_d, sv_q;
    logic          event_hit;
    logic          room_fwd;
    logic          data_rev;

    assign dir = pp_dir_e'(dir_i);

    always_comb begin
        if (dma_en_i) begin
            event_hit = dma_tc_i;
        end else if (dir == PP_FWD) begin
            event_hit = CMP_W'(free_i) >= CMP_W'(wr_thr_i);
        end else begin
            event_hit = CMP_W'(count_i) >= CMP_W'(rd_thr_i);
        end
    end

    always_comb begin
        sv_d = sv_q;
        if (sw_wr_i) begin
            sv_d.svc = sw_val_i;
            if (!sw_val_i) begin
                sv_d.irq = 1'b0;
            end
        end else if (!sv_q.svc && event_hit) begin
            sv_d.svc = 1'b1;
            sv_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sv_q <= '{svc: 1'b1, irq: 1'b0};
        end else begin
            sv_q <= sv_d;
        end
    end

    assign room_fwd  = (dir == PP_FWD) && !full_i;
    assign data_rev  = (dir == PP_REV) && !empty_i;
    assign svc_o     = sv_q.svc;
    assign irq_o     = sv_q.irq;
    assign dma_req_o = dma_en_i && !sv_q.svc && (room_fwd || data_rev);

endmodule

// File: rtl/pp_fifo_svc.sv
module pp_fifo_svc #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int THR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_i,
    input  logic             dma_en_i,
    input  logic             dma_tc_i,
    input  logic [THR_W-1:0] wr_thr_i,
    input  logic [THR_W-1:0] rd_thr_i,
    input  logic             host_wr_i,
    input  logic [DW-1:0]    host_wdata_i,
    input  logic             host_rd_i,
    output logic [DW-1:0]    host_rdata_o,
    input  logic             svc_wr_i,
    input  logic             svc_wdata_i,
    output logic             svc_o,
    output logic             irq_o,
    output logic             dma_req_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             not_full_o,
    output logic             not_empty_o,
    input  logic             pin_valid_i,
    input  logic [DW-1:0]    pin_data_i,
    output logic             pin_ready_o,
    output logic             pout_valid_o,
    output logic [DW-1:0]    pout_data_o,
    input  logic             pout_ready_i
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             push;
    logic [DW-1:0]    push_data;
    logic             pop;
    logic [DW-1:0]    head;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] free;
    logic             full;
    logic             empty;

    pp_fifo_route #(.DW(DW)) u_route (
        .dir_i        (dir_i),
        .host_wr_i    (host_wr_i),
        .host_wdata_i (host_wdata_i),
        .host_rd_i    (host_rd_i),
        .pin_valid_i  (pin_valid_i),
        .pin_data_i   (pin_data_i),
        .pout_ready_i (pout_ready_i),
        .full_i       (full),
        .empty_i      (empty),
        .push_o       (push),
        .push_data_o  (push_data),
        .pop_o        (pop),
        .pin_ready_o  (pin_ready_o),
        .pout_valid_o (pout_valid_o)
    );

    pp_fifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_data_i (push_data),
        .pop_i       (pop),
        .head_o      (head),
        .count_o     (count),
        .free_o      (free),
        .full_o      (full),
        .empty_o     (empty)
    );

    pp_svc_ctl #(.CNT_W(CNT_W), .THR_W(THR_W)) u_svc (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_i     (dir_i),
        .dma_en_i  (dma_en_i),
        .dma_tc_i  (dma_tc_i),
        .wr_thr_i  (wr_thr_i),
        .rd_thr_i  (rd_thr_i),
        .count_i   (count),
        .free_i    (free),
        .full_i    (full),
        .empty_i   (empty),
        .sw_wr_i   (svc_wr_i),
        .sw_val_i  (svc_wdata_i),
        .svc_o     (svc_o),
        .irq_o     (irq_o),
        .dma_req_o (dma_req_o)
    );

    assign host_rdata_o = head;
    assign pout_data_o  = head;
    assign full_o       = full;
    assign empty_o      = empty;
    assign not_full_o   = ~full;
    assign not_empty_o  = ~empty;

endmodule

// File: rtl/pp_fifo_svc_chk.sv
module pp_fifo_svc_chk (
    input logic clk,
    input logic rst_n,
    input logic dir_i,
    input logic dma_en_i,
    input logic dma_tc_i,
    input logic host_wr_i,
    input logic pout_ready_i,
    input logic svc_wr_i,
    input logic svc_wdata_i,
    input logic svc_o,
    input logic irq_o,
    input logic dma_req_o,
    input logic full_o,
    input logic empty_o,
    input logic not_empty_o
);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_o && !dir_i && !pout_ready_i |=> full_o);

    // R2
    fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o && !dir_i && host_wr_i |=> not_empty_o && !empty_o);

    // R5
    sw_set_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_wr_i && svc_wdata_i && !irq_o |=> svc_o && !irq_o);

    // R6
    masked_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_o |-> !dma_req_o);

    // R7
    tc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_en_i && dma_tc_i && !svc_o && !svc_wr_i |=> svc_o && irq_o);

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !(svc_wr_i && !svc_wdata_i) |=> irq_o && svc_o);

    // R10
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_wr_i && !svc_wdata_i |=> !svc_o && !irq_o);

endmodule

bind pp_fifo_svc pp_fifo_svc_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dir_i        (dir_i),
    .dma_en_i     (dma_en_i),
    .dma_tc_i     (dma_tc_i),
    .host_wr_i    (host_wr_i),
    .pout_ready_i (pout_ready_i),
    .svc_wr_i     (svc_wr_i),
    .svc_wdata_i  (svc_wdata_i),
    .svc_o        (svc_o),
    .irq_o        (irq_o),
    .dma_req_o    (dma_req_o),
    .full_o       (full_o),
    .empty_o      (empty_o),
    .not_empty_o  (not_empty_o)
);

// File: tb/pp_fifo_svc_bench.sv
`timescale 1ns/1ps
module pp_fifo_svc_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir_i = 1'b0;
    logic       dma_en_i = 1'b0;
    logic       dma_tc_i = 1'b0;
    logic [3:0] wr_thr_i = '0;
    logic [3:0] rd_thr_i = '0;
    logic       host_wr_i = 1'b0;
    logic [7:0] host_wdata_i = '0;
    logic       host_rd_i = 1'b0;
    logic [7:0] host_rdata_o;
    logic       svc_wr_i = 1'b0;
    logic       svc_wdata_i = 1'b0;
    logic       svc_o, irq_o, dma_req_o;
    logic       full_o, empty_o, not_full_o, not_empty_o;
    logic       pin_valid_i = 1'b0;
    logic [7:0] pin_data_i = '0;
    logic       pin_ready_o, pout_valid_o;
    logic [7:0] pout_data_o;
    logic       pout_ready_i = 1'b0;

    always #2 clk = ~clk;

    pp_fifo_svc u_pp_fifo_svc (.*);

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;
    logic [7:0] q[$];
    bit exp_svc = 1'b1;
    bit exp_irq = 1'b0;

    task automatic chk(input string r, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FIFO check FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check_status(input string r);
        int n = q.size();
        chk({r, " full"}, int'(full_o), int'(n == 16));
        chk({r, " empty"}, int'(empty_o), int'(n == 0));
        chk({r, " not_full"}, int'(not_full_o), int'(n != 16));
        chk({r, " not_empty"}, int'(not_empty_o), int'(n != 0));
    endtask

    task automatic host_push(input logic [7:0] b);
        host_wr_i = 1'b1; host_wdata_i = b;
        step();
        host_wr_i = 1'b0;
        if (!dir_i && q.size() < 16) q.push_back(b);
    endtask

    task automatic per_fill(input logic [7:0] b);
        chk("R4 pin_ready", int'(pin_ready_o), int'(dir_i && q.size() < 16));
        pin_valid_i = 1'b1; pin_data_i = b;
        step();
        pin_valid_i = 1'b0;
        if (dir_i && q.size() < 16) q.push_back(b);
    endtask

    task automatic pop_any();
        if (!dir_i) begin
            chk("R4 pout_valid", int'(pout_valid_o), int'(q.size() != 0));
            if (q.size() != 0) chk("R2 order fwd", int'(pout_data_o), int'(q[0]));
            pout_ready_i = 1'b1;
            step();
            pout_ready_i = 1'b0;
        end else begin
            chk("R4 pout_valid rev", int'(pout_valid_o), 0);
            if (q.size() != 0) chk("R2 order rev", int'(host_rdata_o), int'(q[0]));
            host_rd_i = 1'b1;
            step();
            host_rd_i = 1'b0;
        end
        if (q.size() != 0) void'(q.pop_front());
    endtask

    task automatic svc_write(input bit v);
        svc_wr_i = 1'b1; svc_wdata_i = v;
        step();
        svc_wr_i = 1'b0;
        exp_svc = v;
        if (!v) exp_irq = 1'b0;
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            nfail++;
            $display("FIFO check FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check_status("R1");
        chk("R1 svc", int'(svc_o), 1);
        chk("R1 irq", int'(irq_o), 0);
        chk("R1 dma_req", int'(dma_req_o), 0);

        // Threshold sweep in both directions, every fill level
        for (int d = 0; d < 2; d++) begin
            dir_i = d[0];
            for (int n = 0; n <= 16; n++) begin
                check_status("R2 level");
                for (int t = 0; t < 16; t++) begin
                    bit hit;
                    if (d == 0) begin wr_thr_i = 4'(t); rd_thr_i = 4'd0; end
                    else        begin rd_thr_i = 4'(t); wr_thr_i = 4'd0; end
                    svc_write(1'b0);
                    chk("R10 clear svc", int'(svc_o), 0);
                    chk("R10 clear irq", int'(irq_o), 0);
                    step();
                    hit = (d == 0) ? ((16 - n) >= t) : (n >= t);
                    if (d == 0) chk("R8 fwd threshold", int'(svc_o), int'(hit));
                    else        chk("R9 rev threshold", int'(svc_o), int'(hit));
                    chk("R8 R9 irq follows", int'(irq_o), int'(hit));
                    chk("R11 dma off", int'(dma_req_o), 0);
                    exp_irq = hit;
                    svc_write(1'b1);
                    chk("R5 sw set svc", int'(svc_o), 1);
                    chk("R5 sw set irq", int'(irq_o), int'(exp_irq));
                end
                if (n < 16) begin
                    if (d == 0) host_push(8'(n * 13 + 5));
                    else        per_fill(8'(n * 29 + 101));
                end
            end
            // R3 push to full ignored
            if (d == 0) host_push(8'hEE); else per_fill(8'hEE);
            check_status("R3 full push");
            // R4 inactive strobes ignored
            if (d == 0) begin
                host_rd_i = 1'b1; step(); host_rd_i = 1'b0;
                chk("R4 host_rd ignored fwd", int'(full_o), 1);
            end else begin
                pout_ready_i = 1'b1; step(); pout_ready_i = 1'b0;
                chk("R4 pout_ready ignored rev", int'(full_o), 1);
            end
            // Drain in order
            for (int k = 0; k < 16; k++) pop_any();
            check_status("R2 drained");
            // R3 pop from empty ignored, then one byte round trip
            pop_any();
            check_status("R3 empty pop");
            if (d == 0) begin
                pin_valid_i = 1'b1; pin_data_i = 8'h55; step(); pin_valid_i = 1'b0;
                chk("R4 pin ignored fwd", int'(empty_o), 1);
                host_push(8'hA7);
            end else begin
                host_wr_i = 1'b1; host_wdata_i = 8'h55; step(); host_wr_i = 1'b0;
                chk("R4 host_wr ignored rev", int'(empty_o), 1);
                per_fill(8'h3C);
            end
            check_status("R3 after empty pop");
            pop_any();
            check_status("R2 round trip");
        end

        // DMA mode, forward
        dir_i = 1'b0; dma_en_i = 1'b1; wr_thr_i = 4'd0; rd_thr_i = 4'd0;
        svc_write(1'b1);
        chk("R6 dma masked", int'(dma_req_o), 0);
        svc_write(1'b0);
        chk("R11 dma req fwd room", int'(dma_req_o), 1);
        step();
        chk("R7 thresholds ignored", int'(svc_o), 0);
        dma_tc_i = 1'b1; step(); dma_tc_i = 1'b0;
        chk("R7 tc svc", int'(svc_o), 1);
        chk("R7 tc irq", int'(irq_o), 1);
        chk("R6 dma masked after tc", int'(dma_req_o), 0);
        dma_tc_i = 1'b1; step(); step(); dma_tc_i = 1'b0;
        chk("R10 irq held", int'(irq_o), 1);
        // R10 software clear beats simultaneous tc
        dma_tc_i = 1'b1; svc_write(1'b0); dma_tc_i = 1'b0;
        chk("R10 priority svc", int'(svc_o), 0);
        chk("R10 priority irq", int'(irq_o), 0);
        step();
        chk("R7 no tc no set", int'(svc_o), 0);
        // full forward: no DMA request
        for (int k = 0; k < 16; k++) host_push(8'(k));
        chk("R11 dma req fwd full", int'(dma_req_o), 0);
        // reverse, DMA
        dir_i = 1'b1; step();
        chk("R11 dma req rev data", int'(dma_req_o), 1);
        for (int k = 0; k < 16; k++) pop_any();
        chk("R11 dma req rev empty", int'(dma_req_o), 0);
        per_fill(8'h81);
        chk("R11 dma req rev one", int'(dma_req_o), 1);
        chk("R7 still clear", int'(svc_o), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule